// File: doc/BRIEF.md
# Power Mode Sequencer

This block sequences a solenoid driver through its three power states: off, standby and active. Its inputs are an enable request, a standby request, a supply-valid flag and a halt line from the fault supervisor. It drives two domain power enables and an output-ready strobe that gates the PWM modulator. The core domain feeds the blocks that must stay alive for a quick resume. The auxiliary domain feeds the blocks that can sleep during standby.

There are two wake paths with very different costs. A cold start from off runs a long timer of about ten milliseconds so that the whole chip can settle. A resume from standby runs a short timer of a few microseconds. Both lengths are given in microseconds and converted to clock cycles from the clock rate parameter. Entering off takes a single clock edge. When supply or fault status goes bad, the output-ready strobe drops in the same cycle.

Top module: `pwr_mode_seq`

## Requirements
- R1: While reset is held and right after it, the sequencer is off and coreDomainOn, auxDomainOn and outReady are all 0.
- R2: After any clock edge at which enableIn is sampled low, both domain enables are 0, and outReady is 0 in every cycle that enableIn is low.
- R3: With supply good and no fault, let the first edge with enableIn sampled high from off be edge 0. outReady is then 1 from edge COLD_CYC onward. From edge 0 until then, both domains are on and outReady is 0.
- R4: With enableIn high and standbyIn high after a wake, coreDomainOn is 1, auxDomainOn is 0 and outReady is 0.
- R5: Let the first edge at which standbyIn is sampled low while in standby be edge 0. outReady is 1 from edge WARM_CYC onward, and auxDomainOn is 1 from edge 0.
- R6: If standbyIn rises during a resume, the sequencer goes back to standby. The next resume counts the full WARM_CYC again.
- R7: standbyIn high during a cold start does not shorten it. The cold timer runs to the end and the sequencer then settles in standby with outReady 0.
- R8: enableIn low takes priority over standbyIn high. The next state is off, with coreDomainOn 0.
- R9: supplyOk low or faultHalt high forces outReady to 0 in the same cycle and turns both domains off after the next edge. Once conditions recover, a full cold start (R3) follows.
- R10: COLD_CYC = max(1, CLK_KHZ*COLD_US/1000) and WARM_CYC = max(1, CLK_KHZ*WARM_US/1000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enableIn | input | 1 | Request for power; low means off |
| standbyIn | input | 1 | Request for standby while enabled |
| supplyOk | input | 1 | Supply within valid range |
| faultHalt | input | 1 | Fault supervisor asks for the output to stop |
| coreDomainOn | output | 1 | Power enable for blocks kept alive in standby |
| auxDomainOn | output | 1 | Power enable for blocks switched off in standby |
| outReady | output | 1 | Modulator output may run |

## Verification
The assertions assume that all four control inputs are synchronous to clk and change only between edges. They also assume that reset is applied before any request is evaluated. The bench drives inputs only at falling edges. It keeps enable, standby, supply and fault changes rare and sticky, so that full cold and warm wakes both complete many times under random stimulus. Directed phases then pin down exact wake latencies, standby during wake, priority and supply loss.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_COLD    = 3'd1,
    ST_STANDBY = 3'd2,
    ST_WARM    = 3'd3,
    ST_ACTIVE  = 3'd4
  } pwrState_e;

  // strobes from control to the wake timer
  typedef struct packed {
    logic clr;
    logic run;
  } timerCtl_t;
endpackage

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer
  import pwr_seq_pkg::*;
#(
  parameter int COLD_CYC = 500000,
  parameter int WARM_CYC = 300
) (
  input  logic      clk,
  input  logic      rstN,
  input  timerCtl_t ctl,
  output logic      coldDone,
  output logic      warmDone
);
  localparam int MAXC = (COLD_CYC > WARM_CYC) ? COLD_CYC : WARM_CYC;
  localparam int CW   = (MAXC > 1) ? $clog2(MAXC + 1) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cnt <= '0;
    else if (ctl.clr)
      cnt <= '0;
    else if (ctl.run && cnt != CW'(MAXC - 1))
      cnt <= cnt + 1'b1;
  end

  assign coldDone = (cnt == CW'(COLD_CYC - 1));
  assign warmDone = (cnt == CW'(WARM_CYC - 1));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enableIn,
  input  logic      standbyIn,
  input  logic      supplyOk,
  input  logic      faultHalt,
  input  logic      coldDone,
  input  logic      warmDone,
  output timerCtl_t tmr,
  output logic      coreDomainOn,
  output logic      auxDomainOn,
  output logic      outReady
);
  pwrState_e state, nextState;
  logic runOk;

  assign runOk = enableIn && supplyOk && !faultHalt;

  always_comb begin
    nextState = state;
    tmr       = '0;
    if (!runOk) begin
      nextState = ST_OFF;
    end else begin
      case (state)
        ST_OFF: begin
          nextState = ST_COLD;
          tmr.clr   = 1'b1;
        end
        ST_COLD: begin
          tmr.run = 1'b1;
          if (coldDone) nextState = standbyIn ? ST_STANDBY : ST_ACTIVE;
        end
        ST_STANDBY: begin
          if (!standbyIn) begin
            nextState = ST_WARM;
            tmr.clr   = 1'b1;
          end
        end
        ST_WARM: begin
          if (standbyIn) nextState = ST_STANDBY;
          else begin
            tmr.run = 1'b1;
            if (warmDone) nextState = ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if (standbyIn) nextState = ST_STANDBY;
        end
        default: nextState = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= nextState;
  end

  assign coreDomainOn = (state != ST_OFF);
  assign auxDomainOn  = (state == ST_COLD) || (state == ST_WARM) || (state == ST_ACTIVE);
  assign outReady     = (state == ST_ACTIVE) && runOk && !standbyIn;

  AST_COLD_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF && runOk) |=> (state == ST_COLD)); // R3
  AST_WARM_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STANDBY && runOk && !standbyIn) |=> (state == ST_WARM && !outReady)); // R5
  AST_WARM_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WARM && runOk && standbyIn) |=> (state == ST_STANDBY)); // R6
  AST_SUPPLY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!supplyOk || faultHalt) |=> (state == ST_OFF)); // R9
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
  import pwr_seq_pkg::*;
#(
  parameter int CLK_KHZ = 50000,
  parameter int COLD_US = 10000,
  parameter int WARM_US = 6
) (
  input  logic clk,
  input  logic rstN,
  input  logic enableIn,
  input  logic standbyIn,
  input  logic supplyOk,
  input  logic faultHalt,
  output logic coreDomainOn,
  output logic auxDomainOn,
  output logic outReady
);
  localparam int COLD_RAW = CLK_KHZ * COLD_US / 1000;
  localparam int WARM_RAW = CLK_KHZ * WARM_US / 1000;
  localparam int COLD_CYC = (COLD_RAW < 1) ? 1 : COLD_RAW; // R10
  localparam int WARM_CYC = (WARM_RAW < 1) ? 1 : WARM_RAW; // R10

  timerCtl_t tmrCtl;
  logic coldDone, warmDone;

  pwr_seq_timer #(.COLD_CYC(COLD_CYC), .WARM_CYC(WARM_CYC)) i_timer (
    .clk(clk), .rstN(rstN), .ctl(tmrCtl), .coldDone(coldDone), .warmDone(warmDone)
  );

  pwr_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .enableIn(enableIn), .standbyIn(standbyIn),
    .supplyOk(supplyOk), .faultHalt(faultHalt), .coldDone(coldDone),
    .warmDone(warmDone), .tmr(tmrCtl), .coreDomainOn(coreDomainOn),
    .auxDomainOn(auxDomainOn), .outReady(outReady)
  );

  AST_OFF_ON_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    !enableIn |=> (!coreDomainOn && !auxDomainOn)); // R2
  AST_DISABLE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (!enableIn && standbyIn) |=> !coreDomainOn); // R8
  AST_READY_GATED: assert property (@(posedge clk) disable iff (!rstN)
    outReady |-> (enableIn && supplyOk && !faultHalt)); // R9
endmodule

// File: tb/test_pwr_mode_seq.sv
module test_pwr_mode_seq;
  localparam int CLK_KHZ = 1000;
  localparam int COLD_US = 40;
  localparam int WARM_US = 6;
  localparam int CC = CLK_KHZ * COLD_US / 1000; // R10: 40 cycles
  localparam int WC = CLK_KHZ * WARM_US / 1000; // R10: 6 cycles

  logic clk = 1'b0, rstN = 1'b0;
  logic en = 1'b0, sb = 1'b0, ok = 1'b1, ft = 1'b0;
  logic coreOn, auxOn, rdy;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model: 0 off, 1 cold, 2 standby, 3 warm, 4 active
  int mSt = 0, mLeft = 0;

  always #10 clk = ~clk;

  pwr_mode_seq #(.CLK_KHZ(CLK_KHZ), .COLD_US(COLD_US), .WARM_US(WARM_US)) i_pwr_mode_seq (
    .clk(clk), .rstN(rstN), .enableIn(en), .standbyIn(sb), .supplyOk(ok),
    .faultHalt(ft), .coreDomainOn(coreOn), .auxDomainOn(auxOn), .outReady(rdy)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelStep();
    if (!en || !ok || ft) mSt = 0;
    else case (mSt)
      0: begin mSt = 1; mLeft = CC; end
      1: begin mLeft--; if (mLeft == 0) mSt = sb ? 2 : 4; end
      2: if (!sb) begin mSt = 3; mLeft = WC; end
      3: if (sb) mSt = 2; else begin mLeft--; if (mLeft == 0) mSt = 4; end
      default: if (sb) mSt = 2;
    endcase
  endfunction

  task automatic modelCheck(input string tag);
    chk(coreOn, mSt != 0, {tag, " core"});
    chk(auxOn, mSt == 1 || mSt == 3 || mSt == 4, {tag, " aux"});
    chk(rdy, mSt == 4 && en && !sb && ok && !ft, {tag, " ready"});
  endtask

  // inputs are driven at a falling edge; one rising edge passes; outputs checked at next falling edge
  task automatic step(input logic e, input logic s, input logic o, input logic f, input string tag);
    en = e; sb = s; ok = o; ft = f;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    modelCheck(tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    chk(coreOn, 1'b0, "R1 core in reset");
    chk(auxOn, 1'b0, "R1 aux in reset");
    chk(rdy, 1'b0, "R1 ready in reset");
    rstN = 1'b1;
    @(negedge clk);
    modelCheck("R1 after reset");

    // R3 cold wake exact latency
    for (int k = 1; k <= CC + 2; k++) begin
      step(1, 0, 1, 0, "R3 cold");
      chk(rdy, k > CC, "R3 cold latency");
      chk(auxOn, 1'b1, "R3 aux during wake");
    end
    // R4 standby
    step(1, 1, 1, 0, "R4 standby");
    chk(auxOn, 1'b0, "R4 aux off");
    chk(coreOn, 1'b1, "R4 core on");
    // R5 warm wake exact latency
    for (int k = 1; k <= WC + 1; k++) begin
      step(1, 0, 1, 0, "R5 warm");
      chk(rdy, k > WC, "R5 warm latency");
    end
    // R6 standby during warm restarts it
    step(1, 1, 1, 0, "R6 back to standby");
    step(1, 0, 1, 0, "R6 warm");
    step(1, 0, 1, 0, "R6 warm");
    step(1, 1, 1, 0, "R6 abort");
    chk(auxOn, 1'b0, "R6 aux off after abort");
    for (int k = 1; k <= WC + 1; k++) begin
      step(1, 0, 1, 0, "R6 rewarm");
      chk(rdy, k > WC, "R6 full warm recount");
    end
    // R8 priority: both requests
    step(0, 1, 1, 0, "R8 priority");
    chk(coreOn, 1'b0, "R8 core off");
    // R7 standby during cold wake
    for (int k = 1; k <= CC + 2; k++) begin
      step(1, k > 5, 1, 0, "R7 cold with standby");
      chk(auxOn, k <= CC, "R7 aux until cold end");
    end
    chk(coreOn, 1'b1, "R7 settled in standby");
    chk(rdy, 1'b0, "R7 ready low");
    // R9 supply drop in active
    for (int k = 0; k < WC + 2; k++) step(1, 0, 1, 0, "R9 prep");
    chk(rdy, 1'b1, "R9 active before drop");
    ok = 1'b0; #1;
    chk(rdy, 1'b0, "R9 ready drops same cycle");
    step(1, 0, 0, 0, "R9 supply bad");
    chk(coreOn, 1'b0, "R9 domains off");
    ft = 1'b1;
    step(1, 0, 1, 1, "R9 fault");
    for (int k = 1; k <= CC + 1; k++) begin
      step(1, 0, 1, 0, "R9 recover");
      chk(rdy, k > CC, "R9 full cold after recovery");
    end
    // R2 enable low
    step(0, 0, 1, 0, "R2 disable");
    chk(auxOn, 1'b0, "R2 aux off");
    chk(rdy, 1'b0, "R2 ready off");

    // constrained random with sticky toggles
    for (int n = 0; n < 6000; n++) begin
      logic e, s, o, f;
      e = ($urandom_range(0, 99) < 2) ? ~en : en;
      s = ($urandom_range(0, 99) < 4) ? ~sb : sb;
      o = ($urandom_range(0, 999) < 5) ? ~ok : ok;
      if (!o && $urandom_range(0, 9) < 3) o = 1'b1;
      f = ($urandom_range(0, 999) < 3);
      step(e, s, o, f, "R2-R9 random");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule